// File: doc/BRIEF.md
# Serial Read-Back Responder

This block is the answering half of a three-wire serial port on a display controller. A host selects the device by pulling an active-low chip select. It then clocks 9-bit frames in on a serial data line. Each frame is one flag bit followed by an 8-bit value, most significant bit first.

When a frame is a recognised read command, the block answers on a serial output that has its own output enable. Four of the read commands answer with a single byte at once. Two others answer with three or four bytes after one idle clock. The values returned come from input ports and are captured when the command is decoded.

The block runs on a fast system clock. The serial clock, select and data inputs are taken as already synchronous to that clock. Serial clock edges are found by comparing each sample with the one before. Each high phase and each low phase of the serial clock must last at least two system clocks.

Top module: `rbr_responder`

## Requirements
- R1: While `cs_n` is low, `sdin` is captured on each rising `sclk` edge. Bits are grouped into 9-bit frames: the first bit is the flag, then the opcode, MSB first. A flag of 0 marks a command.
- R2: The single-byte reads use default opcodes 0xDA, 0xDB, 0xDC and 0xA8, and return `id1_val`, `id2_val`, `id3_val` and `temp_val`. `sdout_oe` rises and bit 7 appears on the falling `sclk` edge right after the ninth rising edge.
- R3: Opcode 0x04 returns the 24 bits of `dispid_val`, and opcode 0x09 returns the 32 bits of `status_val`, most significant bit first.
- R4: For the 24-bit and 32-bit reads, the falling edge right after the frame is a dummy. `sdout_oe` stays low through it, and the first bit appears on the following falling edge.
- R5: `sdout` changes only on falling `sclk` edges, so each bit holds steady across the rising edge on which the host samples it.
- R6: `sdout_oe` drops on the rising edge that samples the last bit. A new frame may then follow under the same selection.
- R7: A frame with the flag at 1, or with an opcode not listed in R2 or R3, gets no answer: `sdout_oe` stays low.
- R8: Raising `cs_n` at any point clears the bit count and drops `sdout_oe` on the next system clock. The next selection starts a fresh frame.
- R9: The answer is captured at decode, so changing the value ports while it is being shifted out does not alter `sdout`.
- R10: `sdin` is ignored while an answer is being shifted out.
- R11: After reset, `sdout_oe` and `sdout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low select |
| sdin | input | 1 | Serial data from host |
| id1_val | input | 8 | First identification byte |
| id2_val | input | 8 | Second identification byte |
| id3_val | input | 8 | Third identification byte |
| temp_val | input | 8 | Temperature byte |
| dispid_val | input | 24 | Display identification word |
| status_val | input | 32 | Display status word |
| sdout | output | 1 | Serial data to host, low when not enabled |
| sdout_oe | output | 1 | Drive enable for `sdout` |

## Verification
The bench checks that the dummy clock is present for the long reads only. A design that got this wrong would shift every bit of a long answer by one position, or lose the top bit of a short one.

It aborts a 32-bit answer midway and then issues a short read. A stale bit counter would show up as a misaligned byte.

It rewrites the status port in the middle of an answer and toggles `sdin` throughout every answer. A design that reads the ports live would return a corrupted word, and one that keeps shifting `sdin` in during an answer would corrupt the next frame.

It runs two reads back to back under a single selection, and sends both flagged frames and unknown opcodes. A design that releases the output a cycle late, or answers any frame, would leave `sdout_oe` high where it must be low.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
    localparam int FRAME_BITS = 9;
    localparam int RESP_MAX   = 32;
    localparam int CNT_W      = $clog2(RESP_MAX + 1);

    typedef enum logic [1:0] {
        ST_RECV,
        ST_DUMMY,
        ST_SEND
    } seq_state_e;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_ID1,
        RK_ID2,
        RK_ID3,
        RK_TEMP,
        RK_DISPID,
        RK_STATUS
    } read_kind_e;

    typedef struct packed {
        logic       flag;
        logic [7:0] opcode;
    } frame_t;

    typedef struct packed {
        read_kind_e       kind;
        logic [CNT_W-1:0] nbits;
        logic             dummy;
    } decode_t;

    // Move an n-bit right-aligned value up to the MSB end of the shifter.
    function automatic logic [RESP_MAX-1:0] left_align(input logic [RESP_MAX-1:0] v,
                                                       input logic [CNT_W-1:0]    n);
        return v << (RESP_MAX - int'(n));
    endfunction
endpackage

// File: rtl/rbr_edge.sv
module rbr_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/rbr_frame_rx.sv
module rbr_frame_rx
    import rbr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   en,
    input  logic   rise,
    input  logic   sdin,
    output logic   frame_done,
    output frame_t frame
);
    localparam int CW = $clog2(FRAME_BITS);

    logic [CW-1:0]         cnt_q;
    logic [FRAME_BITS-2:0] sh_q;
    logic                  last_bit;

    assign last_bit = (cnt_q == CW'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (en && rise) begin
            sh_q  <= {sh_q[FRAME_BITS-3:0], sdin};
            cnt_q <= last_bit ? '0 : cnt_q + CW'(1);
        end
    end

    assign frame_done = en & rise & last_bit;
    assign frame      = {sh_q, sdin};
endmodule

// File: rtl/rbr_decode.sv
module rbr_decode
    import rbr_pkg::*;
#(
    parameter logic [7:0] OP_ID1    = 8'hDA,
    parameter logic [7:0] OP_ID2    = 8'hDB,
    parameter logic [7:0] OP_ID3    = 8'hDC,
    parameter logic [7:0] OP_TEMP   = 8'hA8,
    parameter logic [7:0] OP_DISPID = 8'h04,
    parameter logic [7:0] OP_STATUS = 8'h09
) (
    input  frame_t  frame,
    output decode_t dec
);
    always_comb begin
        dec = '{kind: RK_NONE, nbits: '0, dummy: 1'b0};
        if (!frame.flag) begin
            if (frame.opcode == OP_ID1)
                dec = '{kind: RK_ID1, nbits: CNT_W'(8), dummy: 1'b0};
            else if (frame.opcode == OP_ID2)
                dec = '{kind: RK_ID2, nbits: CNT_W'(8), dummy: 1'b0};
            else if (frame.opcode == OP_ID3)
                dec = '{kind: RK_ID3, nbits: CNT_W'(8), dummy: 1'b0};
            else if (frame.opcode == OP_TEMP)
                dec = '{kind: RK_TEMP, nbits: CNT_W'(8), dummy: 1'b0};
            else if (frame.opcode == OP_DISPID)
                dec = '{kind: RK_DISPID, nbits: CNT_W'(24), dummy: 1'b1};
            else if (frame.opcode == OP_STATUS)
                dec = '{kind: RK_STATUS, nbits: CNT_W'(32), dummy: 1'b1};
        end
    end
endmodule

// File: rtl/rbr_responder.sv
module rbr_responder
    import rbr_pkg::*;
#(
    parameter logic [7:0] OP_ID1    = 8'hDA,
    parameter logic [7:0] OP_ID2    = 8'hDB,
    parameter logic [7:0] OP_ID3    = 8'hDC,
    parameter logic [7:0] OP_TEMP   = 8'hA8,
    parameter logic [7:0] OP_DISPID = 8'h04,
    parameter logic [7:0] OP_STATUS = 8'h09
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        sdin,
    input  logic [7:0]  id1_val,
    input  logic [7:0]  id2_val,
    input  logic [7:0]  id3_val,
    input  logic [7:0]  temp_val,
    input  logic [23:0] dispid_val,
    input  logic [31:0] status_val,
    output logic        sdout,
    output logic        sdout_oe
);
    logic       rise, fall;
    logic       frame_done;
    frame_t     frame;
    decode_t    dec;
    seq_state_e st_q;

    logic [RESP_MAX-1:0] word_q, raw_word, word_next;
    logic [CNT_W-1:0]    len_q, txcnt_q;
    logic                oe_q;

    rbr_edge edge_i (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    rbr_frame_rx rx_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (cs_n),
        .en         (st_q == ST_RECV),
        .rise       (rise),
        .sdin       (sdin),
        .frame_done (frame_done),
        .frame      (frame)
    );

    rbr_decode #(
        .OP_ID1    (OP_ID1),
        .OP_ID2    (OP_ID2),
        .OP_ID3    (OP_ID3),
        .OP_TEMP   (OP_TEMP),
        .OP_DISPID (OP_DISPID),
        .OP_STATUS (OP_STATUS)
    ) dec_i (
        .frame (frame),
        .dec   (dec)
    );

    always_comb begin
        case (dec.kind)
            RK_ID1:    raw_word = {24'b0, id1_val};
            RK_ID2:    raw_word = {24'b0, id2_val};
            RK_ID3:    raw_word = {24'b0, id3_val};
            RK_TEMP:   raw_word = {24'b0, temp_val};
            RK_DISPID: raw_word = {8'b0, dispid_val};
            RK_STATUS: raw_word = status_val;
            default:   raw_word = '0;
        endcase
        word_next = left_align(raw_word, dec.nbits);
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            st_q    <= ST_RECV;
            word_q  <= '0;
            len_q   <= '0;
            txcnt_q <= '0;
            oe_q    <= 1'b0;
        end else begin
            case (st_q)
                ST_RECV: begin
                    if (frame_done && dec.kind != RK_NONE) begin
                        word_q  <= word_next;
                        len_q   <= dec.nbits;
                        txcnt_q <= '0;
                        st_q    <= dec.dummy ? ST_DUMMY : ST_SEND;
                    end
                end
                ST_DUMMY: begin
                    if (rise) st_q <= ST_SEND;
                end
                ST_SEND: begin
                    if (fall) begin
                        if (oe_q) word_q <= word_q << 1;
                        else      oe_q   <= 1'b1;
                    end else if (rise && oe_q) begin
                        if (txcnt_q == len_q - CNT_W'(1)) begin
                            oe_q <= 1'b0;
                            st_q <= ST_RECV;
                        end
                        txcnt_q <= txcnt_q + CNT_W'(1);
                    end
                end
                default: st_q <= ST_RECV;
            endcase
        end
    end

    assign sdout    = oe_q & word_q[RESP_MAX-1];
    assign sdout_oe = oe_q;
endmodule

// File: rtl/rbr_checker.sv
module rbr_checker (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic cs_n,
    input logic sdout,
    input logic sdout_oe
);
    logic sclk_d;
    logic rise_c, fall_c;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk;
    end

    assign rise_c = sclk & ~sclk_d;
    assign fall_c = ~sclk & sclk_d;

    // R8
    cs_abort_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !sdout_oe);

    // R5
    sdout_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        (sdout_oe && $past(sdout_oe) && !$stable(sdout)) |-> $past(fall_c));

    // R2
    oe_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdout_oe) |-> $past(fall_c && !cs_n));

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sdout_oe) |-> $past(rise_c || cs_n));

    // R11
    sdout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sdout_oe |-> !sdout);
endmodule

bind rbr_responder rbr_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .sdout    (sdout),
    .sdout_oe (sdout_oe)
);

// File: tb/rbr_responder_tb_top.sv
module rbr_responder_tb_top;
    localparam logic [7:0] K_ID1    = 8'hDA;
    localparam logic [7:0] K_ID2    = 8'hDB;
    localparam logic [7:0] K_ID3    = 8'hDC;
    localparam logic [7:0] K_TEMP   = 8'hA8;
    localparam logic [7:0] K_DISPID = 8'h04;
    localparam logic [7:0] K_STATUS = 8'h09;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdin = 1'b0;
    logic [7:0]  id1_val = '0, id2_val = '0, id3_val = '0, temp_val = '0;
    logic [23:0] dispid_val = '0;
    logic [31:0] status_val = '0;
    logic        sdout, sdout_oe;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #10 clk = ~clk;

    rbr_responder dut_i (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk),
        .cs_n       (cs_n),
        .sdin       (sdin),
        .id1_val    (id1_val),
        .id2_val    (id2_val),
        .id3_val    (id3_val),
        .temp_val   (temp_val),
        .dispid_val (dispid_val),
        .status_val (status_val),
        .sdout      (sdout),
        .sdout_oe   (sdout_oe)
    );

    function automatic int model_len(input logic flag, input logic [7:0] op);
        if (flag) return 0;
        case (op)
            K_ID1, K_ID2, K_ID3, K_TEMP: return 8;
            K_DISPID:                    return 24;
            K_STATUS:                    return 32;
            default:                     return 0;
        endcase
    endfunction

    function automatic logic [31:0] model_word(input logic [7:0] op);
        case (op)
            K_ID1:    return {24'b0, id1_val};
            K_ID2:    return {24'b0, id2_val};
            K_ID3:    return {24'b0, id3_val};
            K_TEMP:   return {24'b0, temp_val};
            K_DISPID: return {8'b0, dispid_val};
            K_STATUS: return status_val;
            default:  return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic flag, input logic [7:0] op);
        logic [8:0] f = {flag, op};
        for (int i = 8; i >= 0; i--) begin
            sdin = f[i];
            wait_clk(2);
            sclk = 1'b1;
            wait_clk(2);
            sclk = 1'b0;
        end
        wait_clk(2);
    endtask

    // Clock out nbits answer bits; optional dummy clock; optional port change at bit chg_at.
    task automatic read_resp(input int nbits, input bit dummy, input int chg_at,
                             output logic [31:0] got, output bit oe_ok,
                             output bit stable_ok, output bit released);
        logic b;
        got = '0; oe_ok = 1; stable_ok = 1; released = 0;
        if (dummy) begin
            // R4: no drive during the dummy clock
            check("R4 dummy oe", {31'b0, sdout_oe}, 32'd0);
            sclk = 1'b1;
            wait_clk(2);
            sclk = 1'b0;
            wait_clk(2);
        end
        for (int i = 0; i < nbits; i++) begin
            if (i == chg_at) status_val = ~status_val;
            if (!sdout_oe) oe_ok = 0;
            b    = sdout;
            got  = {got[30:0], b};
            sdin = 1'($urandom);
            sclk = 1'b1;
            wait_clk(2);
            if (i < nbits - 1) begin
                if (sdout !== b || !sdout_oe) stable_ok = 0;
            end else begin
                released = !sdout_oe;
            end
            sclk = 1'b0;
            wait_clk(2);
        end
    endtask

    // One complete read inside an open selection, checked against the model.
    task automatic do_read(input logic flag, input logic [7:0] op, input string tag);
        int          len;
        logic [31:0] exp, got;
        bit          oe_ok, st_ok, rel;
        len = model_len(flag, op);
        exp = model_word(op);
        send_frame(flag, op);
        if (len == 0) begin
            // R7: no answer, keep clocking with flag=1 frames
            oe_ok = 1;
            for (int i = 0; i < 9; i++) begin
                if (sdout_oe) oe_ok = 0;
                sdin = 1'b1;
                sclk = 1'b1;
                wait_clk(2);
                if (sdout_oe) oe_ok = 0;
                sclk = 1'b0;
                wait_clk(2);
            end
            check({"R7 silent ", tag}, {31'b0, oe_ok}, 32'd1);
        end else begin
            read_resp(len, len > 8, -1, got, oe_ok, st_ok, rel);
            check({"R2/R3 word ", tag}, got, exp);
            check({"R2 oe held ", tag}, {31'b0, oe_ok}, 32'd1);
            check({"R5 stable across rise ", tag}, {31'b0, st_ok}, 32'd1);
            check({"R6 release ", tag}, {31'b0, rel}, 32'd1);
        end
    endtask

    task automatic randomize_ports();
        id1_val    = 8'($urandom);
        id2_val    = 8'($urandom);
        id3_val    = 8'($urandom);
        temp_val   = 8'($urandom);
        dispid_val = 24'($urandom);
        status_val = $urandom;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] got, exp;
        bit          oe_ok, st_ok, rel;
        logic [7:0]  ops [6];
        void'($urandom(32'd4242));
        ops = '{K_ID1, K_ID2, K_ID3, K_TEMP, K_DISPID, K_STATUS};

        wait_clk(4);
        // R11: reset state
        check("R11 reset oe", {31'b0, sdout_oe}, 32'd0);
        check("R11 reset sdout", {31'b0, sdout}, 32'd0);
        rst = 1'b0;
        wait_clk(2);

        // R1 R2 R3 R4: each opcode directed, one selection per read
        randomize_ports();
        foreach (ops[k]) begin
            cs_n = 1'b0; wait_clk(2);
            do_read(1'b0, ops[k], "directed");
            cs_n = 1'b1; wait_clk(2);
        end

        // R7: flagged frame carrying a valid opcode, and an unknown opcode
        cs_n = 1'b0; wait_clk(2);
        do_read(1'b1, K_ID1, "flag set");
        cs_n = 1'b1; wait_clk(2);
        cs_n = 1'b0; wait_clk(2);
        do_read(1'b0, 8'h55, "unknown op");
        cs_n = 1'b1; wait_clk(2);

        // R6: two reads under one selection
        randomize_ports();
        cs_n = 1'b0; wait_clk(2);
        do_read(1'b0, K_ID3, "b2b first");
        do_read(1'b0, K_DISPID, "b2b second");
        cs_n = 1'b1; wait_clk(2);

        // R8: abort a status read after 5 bits, then a clean short read
        randomize_ports();
        cs_n = 1'b0; wait_clk(2);
        send_frame(1'b0, K_STATUS);
        read_resp(5, 1'b1, -1, got, oe_ok, st_ok, rel);
        check("R8 partial bits", got, status_val >> 27);
        cs_n = 1'b1; wait_clk(2);
        check("R8 abort oe", {31'b0, sdout_oe}, 32'd0);
        cs_n = 1'b0; wait_clk(2);
        do_read(1'b0, K_ID2, "after abort");
        cs_n = 1'b1; wait_clk(2);

        // R9: status port flips while the answer is shifting out
        randomize_ports();
        exp = status_val;
        cs_n = 1'b0; wait_clk(2);
        send_frame(1'b0, K_STATUS);
        read_resp(32, 1'b1, 10, got, oe_ok, st_ok, rel);
        check("R9 latched word", got, exp);
        check("R6 release latched", {31'b0, rel}, 32'd1);
        cs_n = 1'b1; wait_clk(2);

        // R1 R10: random mix, sdin toggled during every answer
        for (int it = 0; it < 40; it++) begin
            logic [7:0] op;
            logic       fl;
            randomize_ports();
            op = ($urandom % 4 == 0) ? 8'($urandom) : ops[$urandom % 6];
            fl = ($urandom % 8 == 0);
            cs_n = 1'b0; wait_clk(2);
            do_read(fl, op, "R10 random");
            cs_n = 1'b1; wait_clk(2);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule